// File: doc/BRIEF.md
# Aliased Control and Status Register Bank

This block is the register file of a temperature-monitor peripheral. It holds the threshold-control, status, threshold-value, measurement-control, period, reference-divider and power-up-timing words. It also presents the live temperature sample as a read-only word. Every stored register drives an output port, so the comparator and the measurement sequencer read their fields directly.

Each register occupies a 16-byte slot. Software can reach it at four offsets:

- the plain offset, where a write replaces the register;
- `+0x4`, which ORs in the bits that are 1 in the write data;
- `+0x8`, which clears those bits;
- `+0xC`, which inverts those bits.

Because of these aliases, software can change a single bit in one bus write, without a read-modify-write sequence.

The status word holds interrupt flags. Hardware raises the flags through per-bit set pulses, and software clears them by writing ones. The bus is a single-cycle register interface:

- A write takes effect at the clock edge on which `req_i` and `we_i` are both high.
- Read data is combinational from the address.

Top module: `aliased_csr_bank`

## Requirements
- R1: After reset, every stored register is zero, and all stored registers read back as zero.
- R2: A write at a stored register's plain offset (address bits 3:2 = 00) replaces the register with the write data.
- R3: A write at offset +0x4 (bits 3:2 = 01) ORs the write data into the register.
- R4: A write at offset +0x8 (bits 3:2 = 10) clears every register bit whose write-data bit is 1.
- R5: A write at offset +0xC (bits 3:2 = 11) inverts every register bit whose write-data bit is 1.
- R6: A read at any of the four offsets of a register returns its current value.
- R7: The decoded slots are: threshold control 0x000, status 0x010, temperature 0x020, threshold value 0x030, measurement control 0x200, period 0x270, reference divider 0x280 and power-up timing 0x2B0. Any other address reads as zero, and writes to it change no register. An address whose bits 1:0 are not 00 counts as undecoded.
- R8: For the status word (0x010), a write at the plain offset or at the clear offset clears the flags whose data bits are 1. Writes at the set and toggle offsets are ignored. A flag otherwise stays set.
- R9: A flag whose `flag_set_i` bit is high is set after that edge, even if a software clear of the same bit lands in the same cycle.
- R10: The temperature word (0x020) reads as `temp_i` zero-extended into the low 16 bits. Writes at any of its offsets are ignored.
- R11: No register changes unless `req_i` and `we_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| temp_i | input | 16 | Current temperature sample |
| flag_set_i | input | 32 | Per-bit hardware set pulses for the status flags |
| thr_ctrl_o | output | 32 | Threshold-control register |
| status_o | output | 32 | Status flags |
| thr_val_o | output | 32 | Threshold-value register |
| meas_ctrl_o | output | 32 | Measurement-control register |
| period_o | output | 32 | Measurement-period register |
| ref_div_o | output | 32 | Reference-divider register |
| pud_ctrl_o | output | 32 | Power-up-timing register |

## Verification
The assertions check the following on every cycle:

- the priority of hardware flag sets over software clears;
- that flags never fall without a clearing write;
- that registers stay stable with no write strobe;
- the set, clear and toggle results on sample registers;
- the combinational readback of the temperature word and of misaligned addresses.

Some behaviours only the bench scenarios show. These include:

- equal readback across all four aliases for every register under several data patterns;
- a full byte-address sweep proving that every hole reads zero;
- that writes to holes and to the read-only word disturb nothing.

// File: rtl/acb_pkg.sv
package acb_pkg;
  typedef enum logic [1:0] {OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_TOG = 2'd3} alias_op_e;

  localparam int N_REG        = 8;
  localparam int IDX_THR_CTRL = 0;
  localparam int IDX_STATUS   = 1;
  localparam int IDX_TEMP     = 2;
  localparam int IDX_THR_VAL  = 3;
  localparam int IDX_MEAS     = 4;
  localparam int IDX_PERIOD   = 5;
  localparam int IDX_DIV      = 6;
  localparam int IDX_PUD      = 7;

  function automatic int slot_base(int idx);
    case (idx)
      IDX_THR_CTRL: return 'h000;
      IDX_STATUS:   return 'h010;
      IDX_TEMP:     return 'h020;
      IDX_THR_VAL:  return 'h030;
      IDX_MEAS:     return 'h200;
      IDX_PERIOD:   return 'h270;
      IDX_DIV:      return 'h280;
      default:      return 'h2B0;
    endcase
  endfunction
endpackage

// File: rtl/acb_decode.sv
module acb_decode
  import acb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REG-1:0]  hit_o,
  output alias_op_e         op_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign op_o    = alias_op_e'(addr_i[3:2]);

  for (genvar i = 0; i < N_REG; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(slot_base(i));
    assign hit_o[i] = aligned && (addr_i[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
  end
endmodule

// File: rtl/acb_alias_reg.sv
module acb_alias_reg
  import acb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (op_i)
      OP_WR:   nxt = wdata_i;
      OP_SET:  nxt = q_o | wdata_i;
      OP_CLR:  nxt = q_o & ~wdata_i;
      default: nxt = q_o ^ wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= nxt;
  end
endmodule

// File: rtl/acb_flag_reg.sv
module acb_flag_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr;
  assign clr = clr_en_i ? clr_mask_i : '0;

  // hardware set applied after the clear so it wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr) | set_i;
  end
endmodule

// File: rtl/aliased_csr_bank.sv
module aliased_csr_bank
  import acb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int TEMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [DATA_W-1:0] flag_set_i,
  output logic [DATA_W-1:0] thr_ctrl_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] thr_val_o,
  output logic [DATA_W-1:0] meas_ctrl_o,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] ref_div_o,
  output logic [DATA_W-1:0] pud_ctrl_o
);
  localparam int PAD_W = DATA_W - TEMP_W;

  logic [N_REG-1:0]             hit;
  alias_op_e                    op;
  logic                         wr_en;
  logic [N_REG-1:0][DATA_W-1:0] reg_q;

  assign wr_en = req_i & we_i;

  acb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .hit_o  (hit),
    .op_o   (op)
  );

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    if (i == IDX_STATUS) begin : g_flag
      acb_flag_reg #(.W(DATA_W)) u_flag (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_en_i   (wr_en & hit[i] & ((op == OP_WR) | (op == OP_CLR))),
        .clr_mask_i (wdata_i),
        .set_i      (flag_set_i),
        .q_o        (reg_q[i])
      );
    end else if (i == IDX_TEMP) begin : g_ro
      assign reg_q[i] = {{PAD_W{1'b0}}, temp_i};
    end else begin : g_rw
      acb_alias_reg #(.W(DATA_W)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en & hit[i]),
        .op_i    (op),
        .wdata_i (wdata_i),
        .q_o     (reg_q[i])
      );
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (hit[i]) rdata_o = rdata_o | reg_q[i];
    end
  end

  assign thr_ctrl_o  = reg_q[IDX_THR_CTRL];
  assign status_o    = reg_q[IDX_STATUS];
  assign thr_val_o   = reg_q[IDX_THR_VAL];
  assign meas_ctrl_o = reg_q[IDX_MEAS];
  assign period_o    = reg_q[IDX_PERIOD];
  assign ref_div_o   = reg_q[IDX_DIV];
  assign pud_ctrl_o  = reg_q[IDX_PUD];
endmodule

// File: rtl/acb_chk.sv
module acb_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int TEMP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [TEMP_W-1:0] temp_i,
  input logic [DATA_W-1:0] flag_set_i,
  input logic [DATA_W-1:0] thr_ctrl_o,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] thr_val_o,
  input logic [DATA_W-1:0] meas_ctrl_o,
  input logic [DATA_W-1:0] period_o,
  input logic [DATA_W-1:0] ref_div_o,
  input logic [DATA_W-1:0] pud_ctrl_o
);
  logic wr;
  assign wr = req_i && we_i;

  // R2
  period_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(12'h270) |=> period_o == $past(wdata_i));

  // R3
  thr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(12'h004) |=> thr_ctrl_o == ($past(thr_ctrl_o) | $past(wdata_i)));

  // R4
  thr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(12'h008) |=> thr_ctrl_o == ($past(thr_ctrl_o) & ~$past(wdata_i)));

  // R5
  meas_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(12'h20C) |=> meas_ctrl_o == ($past(meas_ctrl_o) ^ $past(wdata_i)));

  // R7
  misaligned_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[1:0] != 2'b00 |-> rdata_o == '0);

  // R7
  hole_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(12'h100) |-> rdata_o == '0);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (addr_i == ADDR_W'(12'h010) || addr_i == ADDR_W'(12'h018)))
    |=> (status_o & $past(status_o)) == $past(status_o));

  // R9
  flag_set_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_i != '0 |=> (status_o & $past(flag_set_i)) == $past(flag_set_i));

  // R10
  temp_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(12'h020) |-> rdata_o == DATA_W'(temp_i));

  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(thr_ctrl_o) && $stable(thr_val_o) && $stable(meas_ctrl_o)
            && $stable(period_o) && $stable(ref_div_o) && $stable(pud_ctrl_o));
endmodule

bind aliased_csr_bank acb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEMP_W(TEMP_W)) u_acb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .temp_i      (temp_i),
  .flag_set_i  (flag_set_i),
  .thr_ctrl_o  (thr_ctrl_o),
  .status_o    (status_o),
  .thr_val_o   (thr_val_o),
  .meas_ctrl_o (meas_ctrl_o),
  .period_o    (period_o),
  .ref_div_o   (ref_div_o),
  .pud_ctrl_o  (pud_ctrl_o)
);

// File: tb/aliased_csr_bank_bench.sv
module aliased_csr_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] temp_i = '0;
  logic [31:0] flag_set_i = '0;
  logic [31:0] thr_ctrl_o, status_o, thr_val_o, meas_ctrl_o, period_o, ref_div_o, pud_ctrl_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m [8];

  always #4 clk_i = ~clk_i;

  aliased_csr_bank u_aliased_csr_bank (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .temp_i, .flag_set_i,
    .thr_ctrl_o, .status_o, .thr_val_o, .meas_ctrl_o, .period_o, .ref_div_o, .pud_ctrl_o
  );

  function automatic int base_of(int i);
    case (i)
      0: return 'h000; 1: return 'h010; 2: return 'h020; 3: return 'h030;
      4: return 'h200; 5: return 'h270; 6: return 'h280; default: return 'h2B0;
    endcase
  endfunction

  function automatic int idx_of(logic [11:0] a);
    if (a[1:0] != 2'b00) return -1;
    for (int i = 0; i < 8; i++) if ({a[11:4], 4'h0} == 12'(base_of(i))) return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_rd(logic [11:0] a);
    int i;
    i = idx_of(a);
    if (i < 0) return '0;
    if (i == 2) return {16'h0, temp_i};
    return m[i];
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    int i;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    i = idx_of(a);
    if (i >= 0 && i != 2) begin
      if (i == 1) begin
        if (a[3:2] == 2'b00 || a[3:2] == 2'b10) m[1] = m[1] & ~d;
      end else begin
        case (a[3:2])
          2'b00: m[i] = d;
          2'b01: m[i] = m[i] | d;
          2'b10: m[i] = m[i] & ~d;
          default: m[i] = m[i] ^ d;
        endcase
      end
    end
  endtask

  task automatic do_read(logic [11:0] a, string tag);
    logic [31:0] e;
    addr_i = a; req_i = 1'b1; we_i = 1'b0;
    #1;
    e = model_rd(a);
    check(rdata_o === e, tag, rdata_o, e);
    req_i = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 8; i++) do_read(12'(base_of(i)), tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    read_all("R1");
    check(thr_ctrl_o == 0 && status_o == 0 && period_o == 0, "R1", thr_ctrl_o | status_o | period_o, 0);

    // R2..R6 all stored registers, all ops, several patterns, readback at every alias
    for (int r = 0; r < 8; r++) begin
      if (r == 1 || r == 2) continue;
      for (int p = 0; p < 4; p++) begin
        for (int op = 0; op < 4; op++) begin
          logic [31:0] d;
          case (p)
            0: d = 32'hA5A5_0F0F;
            1: d = 32'hFFFF_FFFF;
            2: d = 32'h1234_5678 ^ (32'(r) << 8);
            default: d = 32'h1 << (r * 3 + op);
          endcase
          do_write(12'(base_of(r) + op * 4), d);
          for (int al = 0; al < 4; al++)
            do_read(12'(base_of(r) + al * 4),
                    op == 0 ? "R2/R6" : op == 1 ? "R3/R6" : op == 2 ? "R4/R6" : "R5/R6");
        end
      end
    end
    check(meas_ctrl_o === m[4], "R5 port", meas_ctrl_o, m[4]);
    check(ref_div_o === m[6], "R2 port", ref_div_o, m[6]);

    // R11 strobes without a write
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 12'h030; wdata_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b1; addr_i = 12'h200;
    @(negedge clk_i);
    we_i = 1'b0;
    read_all("R11");

    // R8 status flags
    @(negedge clk_i);
    flag_set_i = 32'h0000_F0F3;
    @(negedge clk_i);
    flag_set_i = '0;
    m[1] = 32'h0000_F0F3;
    do_read(12'h010, "R8 set");
    do_write(12'h014, 32'hFFFF_0000);
    do_read(12'h010, "R8 set alias ignored");
    do_write(12'h01C, 32'hFFFF_FFFF);
    do_read(12'h01C, "R8 toggle alias ignored");
    do_write(12'h018, 32'h0000_0003);
    do_read(12'h010, "R8 clear alias");
    do_write(12'h010, 32'h0000_F000);
    do_read(12'h014, "R8 plain w1c");
    check(status_o === m[1], "R8 port", status_o, m[1]);

    // R9 set beats same-cycle clear
    @(negedge clk_i);
    flag_set_i = 32'h0000_0108;
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'h018; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    flag_set_i = '0; req_i = 1'b0; we_i = 1'b0;
    m[1] = 32'h0000_0108;
    do_read(12'h010, "R9");
    check(status_o === 32'h0000_0108, "R9 port", status_o, 32'h0000_0108);

    // R10 temperature word
    for (int t = 0; t < 6; t++) begin
      temp_i = 16'(16'h8001 * t + 16'h00F3 * (t * t));
      for (int al = 0; al < 4; al++) do_read(12'(12'h020 + al * 4), "R10");
    end
    for (int al = 0; al < 4; al++) begin
      do_write(12'(12'h020 + al * 4), 32'h5A5A_5A5A);
      do_read(12'h020, "R10 write ignored");
    end

    // R7 writes to holes and misaligned addresses change nothing
    do_write(12'h100, 32'hFFFF_FFFF);
    do_write(12'h001, 32'hFFFF_FFFF);
    do_write(12'h272, 32'hFFFF_FFFF);
    do_write(12'hFFC, 32'hFFFF_FFFF);
    read_all("R7 write hole");

    // R7 full byte-address read sweep
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk_i);
      do_read(12'(a), "R7 sweep");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule